// File: doc/BRIEF.md
# Two-Channel Multiplexed Overflow Indicator

This block turns the overrange pulses of a stereo converter's two channels into one active-low, open-drain style indicator line. Each channel keeps a sticky flag. The block places the left and right flags on the shared line in alternating slots that follow the left/right frame clock. A downstream device can then demultiplex the line by latching it on the frame clock edges, in the same way it latches the serial audio data.

A flag is set in the clock cycle after its channel reports an overrange. The two flags are held by one shared hold-off counter that counts frames. Any overrange, on either channel, restarts that counter. When the counter runs out, both flags clear together.

The line is refreshed a fixed number of serial-clock falling edges after each frame clock transition. The count depends on the serial format: one edge for left-justified framing and two for the delayed, I2S-style framing. The format also decides which channel's slot follows which frame clock level. All inputs are sampled in a single fast system clock domain. The block provides a drive-low enable together with a pad value that is either 0 or high impedance.

Top module: `ovfl_mux_flag`

## Requirements
- R1: After synchronous reset, both flags are clear and the line is released: the drive-low enable is 0.
- R2: The drive-low enable is 1 during a slot only if the flag of the channel owning that slot was set when the slot was refreshed. Otherwise it is 0.
- R3: A one-cycle pulse on a channel's overrange input sets that channel's flag on the next clock edge. The flag then appears in that channel's next slot.
- R4: Both flags clear together on the TIMEOUT_FRAMES-th rising edge of the frame clock after the most recent overrange. Until then they stay set.
- R5: An overrange on either channel restarts the hold-off count for both flags. A flag set earlier then survives past the point where it would otherwise have expired.
- R6: After a frame clock transition, the line is refreshed on the first following serial-clock falling edge when fmt_i2s_i is 0 (left-justified). It is refreshed on the second such edge when fmt_i2s_i is 1 (I2S). A serial-clock fall in the same cycle as the transition is not counted.
- R7: With fmt_i2s_i = 0, the slot that follows a falling frame clock edge (frame clock low) carries the right flag, and the slot that follows a rising edge carries the left flag. With fmt_i2s_i = 1 this is reversed: frame clock high carries right and frame clock low carries left.
- R8: The pad output is 0 while the drive-low enable is 1 and high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial bit clock, sampled |
| lrck_i | input | 1 | Left/right frame clock, sampled |
| fmt_i2s_i | input | 1 | 0 = left-justified framing, 1 = I2S framing |
| ovr_left_i | input | 1 | One-cycle overrange pulse, left channel |
| ovr_right_i | input | 1 | One-cycle overrange pulse, right channel |
| ovfl_drive_low_o | output | 1 | 1 = pull the indicator line low |
| ovfl_pad_o | output | 1 | Resolved pad value: 0 when driving, Z when released |

## Verification
The hardest state to reach from the ports is a restart of the shared hold-off by the opposite channel shortly before the first flag would expire. Reaching it needs overrange pulses placed a precise number of frame edges apart. The bench gets there with a directed sequence: a left pulse, two frames of waiting, then a right pulse. Seeded random pulses on both channels follow, mixed with format changes in the middle of half-frames. A bench model derived from the requirements tracks flags and frame counts, and every slot is compared against it.

// File: rtl/ovfl_pkg.sv
package ovfl_pkg;

    typedef enum logic {
        FMT_LEFT_JUST = 1'b0,
        FMT_I2S       = 1'b1
    } frame_fmt_e;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    localparam int unsigned NUM_CHAN  = 2;
    localparam int unsigned LJ_DELAY  = 1;
    localparam int unsigned I2S_DELAY = 2;
    localparam int unsigned PEND_W    = $clog2(I2S_DELAY + 1);

    typedef logic [NUM_CHAN-1:0] flag_vec_t;   // index 0 = left, 1 = right

    // Serial-clock falling edges between a frame edge and the refresh
    function automatic logic [PEND_W-1:0] slot_delay(frame_fmt_e fmt);
        return (fmt == FMT_I2S) ? PEND_W'(I2S_DELAY) : PEND_W'(LJ_DELAY);
    endfunction

    // Channel owning the slot that begins after a frame edge to level lrck_now
    function automatic side_e side_after_edge(frame_fmt_e fmt, logic lrck_now);
        logic is_right;
        is_right = (fmt == FMT_I2S) ? lrck_now : ~lrck_now;
        return is_right ? SIDE_RIGHT : SIDE_LEFT;
    endfunction

    function automatic logic pick_flag(flag_vec_t flags, side_e side);
        return (side == SIDE_RIGHT) ? flags[1] : flags[0];
    endfunction

endpackage

// File: rtl/ovfl_edge_det.sv
module ovfl_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
    assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/ovfl_hold_timer.sv
module ovfl_hold_timer
    import ovfl_pkg::*;
#(
    parameter int unsigned TIMEOUT_FRAMES = 256
) (
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t ovr_i,
    input  logic      frame_tick_i,
    output flag_vec_t flags_o
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_FRAMES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_FRAMES - 1);

    logic [CNT_W-1:0] frame_cnt;
    logic             any_ovr;
    logic             expire;

    assign any_ovr = |ovr_i;
    assign expire  = frame_tick_i && (|flags_o) && (frame_cnt == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= '0;
        end else if (any_ovr) begin
            frame_cnt <= '0;
        end else if (frame_tick_i && (|flags_o)) begin
            frame_cnt <= expire ? '0 : frame_cnt + 1'b1;
        end
    end

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst)              flags_o[ch] <= 1'b0;
            else if (ovr_i[ch])   flags_o[ch] <= 1'b1;
            else if (any_ovr)     flags_o[ch] <= flags_o[ch];
            else if (expire)      flags_o[ch] <= 1'b0;
        end

        // R3
        flag_set_chk: assert property (@(posedge clk) disable iff (rst)
            ovr_i[ch] |=> flags_o[ch]);

        // R4
        flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(flags_o[ch]) |-> ($past(frame_tick_i) && !$past(any_ovr)));
    end

    // R5
    restart_keep_chk: assert property (@(posedge clk) disable iff (rst)
        any_ovr |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

// File: rtl/ovfl_slot_mux.sv
module ovfl_slot_mux
    import ovfl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fmt_i2s_i,
    input  logic      lrck_i,
    input  logic      lrck_edge_i,
    input  logic      sclk_fall_i,
    input  flag_vec_t flags_i,
    output logic      drive_low_o
);
    logic [PEND_W-1:0] pend;
    side_e             side_q;
    frame_fmt_e        fmt;

    assign fmt = frame_fmt_e'(fmt_i2s_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend        <= '0;
            side_q      <= SIDE_LEFT;
            drive_low_o <= 1'b0;
        end else if (lrck_edge_i) begin
            pend   <= slot_delay(fmt);
            side_q <= side_after_edge(fmt, lrck_i);
        end else if (sclk_fall_i && (pend != '0)) begin
            pend <= pend - 1'b1;
            if (pend == PEND_W'(1)) drive_low_o <= pick_flag(flags_i, side_q);
        end
    end

    // R6
    refresh_on_sclk_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(drive_low_o) |-> ($past(sclk_fall_i) && !$past(lrck_edge_i)));

    // R2
    drive_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_low_o) |-> $past(|flags_i));
endmodule

// File: rtl/ovfl_mux_flag.sv
module ovfl_mux_flag
    import ovfl_pkg::*;
#(
    parameter int unsigned TIMEOUT_FRAMES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic lrck_i,
    input  logic fmt_i2s_i,
    input  logic ovr_left_i,
    input  logic ovr_right_i,
    output logic ovfl_drive_low_o,
    output wire  ovfl_pad_o
);
    logic      lrck_rise, lrck_fall, sclk_rise, sclk_fall;
    flag_vec_t flags;
    flag_vec_t ovr;

    assign ovr = {ovr_right_i, ovr_left_i};

    ovfl_edge_det lrck_det_i (
        .clk(clk), .rst(rst), .sig_i(lrck_i), .rise_o(lrck_rise), .fall_o(lrck_fall)
    );

    ovfl_edge_det sclk_det_i (
        .clk(clk), .rst(rst), .sig_i(sclk_i), .rise_o(sclk_rise), .fall_o(sclk_fall)
    );

    ovfl_hold_timer #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) timer_i (
        .clk(clk), .rst(rst), .ovr_i(ovr), .frame_tick_i(lrck_rise), .flags_o(flags)
    );

    ovfl_slot_mux mux_i (
        .clk(clk), .rst(rst), .fmt_i2s_i(fmt_i2s_i), .lrck_i(lrck_i),
        .lrck_edge_i(lrck_rise | lrck_fall), .sclk_fall_i(sclk_fall),
        .flags_i(flags), .drive_low_o(ovfl_drive_low_o)
    );

    assign ovfl_pad_o = ovfl_drive_low_o ? 1'b0 : 1'bz;

    logic unused_rise;
    assign unused_rise = sclk_rise;
endmodule

// File: tb/ovfl_mux_flag_tb.sv
module ovfl_mux_flag_tb_top;
    localparam int TO = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, lrck = 1'b0, fmt = 1'b0;
    logic ovr_l = 1'b0, ovr_r = 1'b0;
    logic drive;
    wire  pad;

    int ph = 0;
    int nchk = 0, nerr = 0;
    bit done = 0;
    bit m_l = 0, m_r = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    ovfl_mux_flag #(.TIMEOUT_FRAMES(TO)) dut_i (
        .clk(clk), .rst(rst), .sclk_i(sclk), .lrck_i(lrck), .fmt_i2s_i(fmt),
        .ovr_left_i(ovr_l), .ovr_right_i(ovr_r),
        .ovfl_drive_low_o(drive), .ovfl_pad_o(pad)
    );

    task automatic check(input bit got, input bit exp, input string tag);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %0b expected %0b (ph=%0d)", tag, got, exp, ph);
        end
    endtask

    // One system clock: advance clocks, drive pulses, update requirement model
    task automatic tick(input bit pl = 0, input bit pr = 0);
        bit old_lrck;
        @(negedge clk);
        old_lrck = lrck;
        ph++;
        sclk  = ph[1];
        lrck  = ph[7];
        ovr_l = pl;
        ovr_r = pr;
        if (pl || pr) begin
            m_l |= pl;
            m_r |= pr;
            m_cnt = 0;
        end else if (!old_lrck && lrck && (m_l || m_r)) begin
            if (m_cnt == TO - 1) begin
                m_l = 0; m_r = 0; m_cnt = 0;
            end else m_cnt++;
        end
    endtask

    function automatic bit right_slot(input bit lvl, input bit i2s);
        return i2s ? lvl : ~lvl;
    endfunction

    task automatic goto_off(input int off);
        tick();
        while ((ph % 128) != off) tick();
    endtask

    task automatic pulse(input bit pl, input bit pr, input int off);
        goto_off(off - 1);
        tick(pl, pr);
    endtask

    // Sample a slot well after its refresh and compare with the model
    task automatic check_half(input string tag);
        bit rs;
        goto_off(0);
        rs = right_slot(lrck, fmt);
        goto_off(12);
        check(drive, rs ? m_r : m_l, tag);
        if (drive) check(pad === 1'b0, 1'b1, "R8 pad low while driving");
    endtask

    // Refresh timing: wait for a slot of the chosen side that follows a released slot
    task automatic check_timing(input bit want_right, input string tag);
        do goto_off(0); while (right_slot(lrck, fmt) != want_right);
        goto_off(3);
        check(drive, 1'b0, {tag, " before refresh"});
        goto_off(7);
        check(drive, fmt ? 1'b0 : 1'b1, {tag, " after first sclk fall"});
        goto_off(11);
        check(drive, 1'b1, {tag, " after second sclk fall"});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(drive, 1'b0, "R1 reset releases line");
        rst = 1'b0;
        tick();
        check(drive, 1'b0, "R1 after reset");

        check_half("R2 idle slot");
        check_half("R2 idle slot");

        // Left-justified: left flag, timing and channel order
        fmt = 1'b0;
        pulse(1, 0, 60);
        check_timing(1'b0, "R6 LJ left slot");
        for (int i = 0; i < 4; i++) check_half("R7 LJ order / R3 flag held");
        for (int i = 0; i < 8; i++) check_half("R4 timeout expiry");
        check(m_l || m_r, 1'b0, "R4 model expired");
        check_half("R4 released after timeout");

        // Restart of shared hold-off by the opposite channel
        pulse(1, 0, 60);
        for (int i = 0; i < 4; i++) check_half("R5 before restart");
        pulse(0, 1, 60);
        for (int i = 0; i < 6; i++) check_half("R5 left kept by right restart");
        for (int i = 0; i < 6; i++) check_half("R4 after restart");

        // I2S framing
        for (int i = 0; i < 10; i++) tick();
        fmt = 1'b1;
        check_half("R2 idle I2S");
        pulse(0, 1, 60);
        check_timing(1'b1, "R6 I2S right slot");
        for (int i = 0; i < 4; i++) check_half("R7 I2S order");

        // Seeded random pulses and format changes
        void'($urandom(32'h5eed_0a11));
        for (int i = 0; i < 60; i++) begin
            int r;
            r = $urandom % 8;
            if (r == 0) begin
                goto_off(64);
                fmt = $urandom % 2;
            end else if (r < 3) begin
                pulse($urandom % 2, $urandom % 2, 30 + ($urandom % 60));
            end
            check_half("R7 random slot");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule